// File: doc/BRIEF.md
# Twin-Port RAM with Same-Address Conflict Arbitration

This block is a synchronous RAM with two ports, left and right, on one shared clock. Each port has its own enable, write strobe, address, write data and read data, so both ports can reach the array in the same cycle. Reads are registered and return data one cycle after the access.

A small control unit compares the two enabled accesses in every cycle and sorts them into four cases:

- no shared address;
- a shared read;
- a shared write;
- a read racing a write.

A shared write lets the left port win and drops the right write. A read that races a write returns the contents from before the write. A port that lost a conflict sees its busy flag high in the same cycle as its read data, so the requester can retry. A registered conflict class is also output for the whole RAM.

Top module: `twin_port_ram`

## Requirements
- R1: After reset both busy flags are 0, both read-data outputs are 0 and the conflict class is 0.
- R2: A write on either port stores its data. A read on either port returns the stored word on its read-data output one cycle later.
- R3: Enabled accesses to different addresses, or accesses where one port is disabled, never conflict. Every access completes, both busy flags are 0 in the following cycle, and the conflict class is 0 (none).
- R4: Two reads of one address in one cycle both return the stored word. No busy flag is raised, and the conflict class is 1 (shared read).
- R5: Two writes to one address in one cycle store only the left port's data. Next cycle the right busy flag is 1, the left busy flag is 0, and the conflict class is 2 (shared write).
- R6: When one port reads the address the other port writes in the same cycle, the reader gets the word held before that write. The write is stored. Next cycle the reader's busy flag is 1, the writer's is 0, and the conflict class is 3 (read against write). This holds in both directions.
- R7: Busy flags and the conflict class describe only the access of the previous cycle. They return to 0 after a cycle with no conflict.
- R8: A port's read-data output keeps its last read value while that port writes or is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rstN | input | 1 | Active-low synchronous reset |
| leftEn | input | 1 | Left port access enable |
| leftWe | input | 1 | Left port write (1) or read (0) |
| leftAddr | input | ADDR_W | Left port word address |
| leftWrData | input | DATA_W | Left port write data |
| leftRdData | output | DATA_W | Left port registered read data |
| leftBusy | output | 1 | Left port lost a conflict last cycle |
| rightEn | input | 1 | Right port access enable |
| rightWe | input | 1 | Right port write (1) or read (0) |
| rightAddr | input | ADDR_W | Right port word address |
| rightWrData | input | DATA_W | Right port write data |
| rightRdData | output | DATA_W | Right port registered read data |
| rightBusy | output | 1 | Right port lost a conflict last cycle |
| collKind | output | 2 | Conflict class of last cycle: 0 none, 1 shared read, 2 shared write, 3 read against write |

## Verification
The hardest case to reach is a read racing a write to the same word. The stimulus must prove that the reader saw the pre-write value and that the write still landed. The bench first seeds known words. It then drives the racing pair in one cycle, in each direction. A plain read of the same word follows, to expose the new contents. A shared write is handled the same way: a follow-up read shows that only the left data survived.

// File: rtl/twin_port_pkg.sv
package twin_port_pkg;

  typedef enum logic [1:0] {
    COLL_NONE = 2'b00,
    COLL_RR   = 2'b01,
    COLL_WW   = 2'b10,
    COLL_RW   = 2'b11
  } collKind_e;

  typedef struct packed {
    logic wrLeft;
    logic wrRight;
    logic rdLeft;
    logic rdRight;
  } memStrobes_t;

endpackage

// File: rtl/twin_port_ctrl.sv
module twin_port_ctrl
  import twin_port_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              leftEn,
  input  logic              leftWe,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              rightEn,
  input  logic              rightWe,
  input  logic [ADDR_W-1:0] rightAddr,
  output memStrobes_t       strobes,
  output logic              leftBusy,
  output logic              rightBusy,
  output logic [1:0]        collKind
);

  logic      sameAddr;
  logic      bothWrite;
  logic      bothRead;
  logic      leftLosesRead;
  logic      rightLosesRead;
  collKind_e kindNext;

  always_comb begin
    sameAddr       = leftEn && rightEn && (leftAddr == rightAddr);
    bothWrite      = sameAddr && leftWe && rightWe;
    bothRead       = sameAddr && !leftWe && !rightWe;
    leftLosesRead  = sameAddr && !leftWe && rightWe;
    rightLosesRead = sameAddr && leftWe && !rightWe;

    strobes.wrLeft  = leftEn && leftWe;
    strobes.wrRight = rightEn && rightWe && !bothWrite;
    strobes.rdLeft  = leftEn && !leftWe;
    strobes.rdRight = rightEn && !rightWe;

    if (bothWrite)                          kindNext = COLL_WW;
    else if (leftLosesRead || rightLosesRead) kindNext = COLL_RW;
    else if (bothRead)                      kindNext = COLL_RR;
    else                                    kindNext = COLL_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftBusy  <= 1'b0;
      rightBusy <= 1'b0;
      collKind  <= COLL_NONE;
    end else begin
      leftBusy  <= leftLosesRead;
      rightBusy <= bothWrite || rightLosesRead;
      collKind  <= kindNext;
    end
  end

  AST_WW_RIGHT_LOSES: assert property (@(posedge clk) disable iff (!rstN)
    (leftEn && rightEn && leftWe && rightWe && leftAddr == rightAddr)
    |=> (rightBusy && !leftBusy && collKind == 2'b10)) else $error("ww"); // R5

  AST_RW_LEFT_READER: assert property (@(posedge clk) disable iff (!rstN)
    (leftEn && rightEn && !leftWe && rightWe && leftAddr == rightAddr)
    |=> (leftBusy && !rightBusy && collKind == 2'b11)) else $error("rw l"); // R6

  AST_RW_RIGHT_READER: assert property (@(posedge clk) disable iff (!rstN)
    (leftEn && rightEn && leftWe && !rightWe && leftAddr == rightAddr)
    |=> (rightBusy && !leftBusy && collKind == 2'b11)) else $error("rw r"); // R6

  AST_RR_NO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (leftEn && rightEn && !leftWe && !rightWe && leftAddr == rightAddr)
    |=> (!leftBusy && !rightBusy && collKind == 2'b01)) else $error("rr"); // R4

  AST_DISTINCT_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (!leftEn || !rightEn || leftAddr != rightAddr)
    |=> (!leftBusy && !rightBusy && collKind == 2'b00)) else $error("free"); // R3

endmodule

// File: rtl/twin_port_mem.sv
module twin_port_mem
  import twin_port_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobes_t       strobes,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic [DATA_W-1:0] leftWrData,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic [DATA_W-1:0] rightWrData,
  output logic [DATA_W-1:0] leftRdData,
  output logic [DATA_W-1:0] rightRdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrLeft)  store[leftAddr]  <= leftWrData;
    if (strobes.wrRight) store[rightAddr] <= rightWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftRdData  <= '0;
      rightRdData <= '0;
    end else begin
      if (strobes.rdLeft)  leftRdData  <= store[leftAddr];
      if (strobes.rdRight) rightRdData <= store[rightAddr];
    end
  end

  AST_ONE_WRITER_PER_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrLeft && strobes.wrRight) |-> (leftAddr != rightAddr)) else $error("two writers"); // R5

  AST_LEFT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrLeft |=> (store[$past(leftAddr)] == $past(leftWrData))) else $error("left write"); // R2

  AST_HOLD_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdLeft |=> $stable(leftRdData)) else $error("hold"); // R8

endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
  import twin_port_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              leftEn,
  input  logic              leftWe,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic [DATA_W-1:0] leftWrData,
  output logic [DATA_W-1:0] leftRdData,
  output logic              leftBusy,
  input  logic              rightEn,
  input  logic              rightWe,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic [DATA_W-1:0] rightWrData,
  output logic [DATA_W-1:0] rightRdData,
  output logic              rightBusy,
  output logic [1:0]        collKind
);

  memStrobes_t strobes;

  twin_port_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .leftEn(leftEn), .leftWe(leftWe), .leftAddr(leftAddr),
    .rightEn(rightEn), .rightWe(rightWe), .rightAddr(rightAddr),
    .strobes(strobes), .leftBusy(leftBusy), .rightBusy(rightBusy),
    .collKind(collKind)
  );

  twin_port_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .leftAddr(leftAddr), .leftWrData(leftWrData),
    .rightAddr(rightAddr), .rightWrData(rightWrData),
    .leftRdData(leftRdData), .rightRdData(rightRdData)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!leftBusy && !rightBusy && collKind == 2'b00 && leftRdData == '0)) else $error("reset"); // R1

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (!leftEn && !rightEn) |=> (!leftBusy && !rightBusy && collKind == 2'b00)) else $error("stale"); // R7

endmodule

// File: tb/test_twin_port_ram.sv
module test_twin_port_ram;

  localparam int AW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          leftEn = 1'b0, leftWe = 1'b0, rightEn = 1'b0, rightWe = 1'b0;
  logic [AW-1:0] leftAddr = '0, rightAddr = '0;
  logic [DW-1:0] leftWrData = '0, rightWrData = '0;
  logic [DW-1:0] leftRdData, rightRdData;
  logic          leftBusy, rightBusy;
  logic [1:0]    collKind;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  twin_port_ram #(.ADDR_W(AW), .DATA_W(DW)) i_twin_port_ram (
    .clk(clk), .rstN(rstN),
    .leftEn(leftEn), .leftWe(leftWe), .leftAddr(leftAddr), .leftWrData(leftWrData),
    .leftRdData(leftRdData), .leftBusy(leftBusy),
    .rightEn(rightEn), .rightWe(rightWe), .rightAddr(rightAddr), .rightWrData(rightWrData),
    .rightRdData(rightRdData), .rightBusy(rightBusy), .collKind(collKind)
  );

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic access(logic le, logic lw, logic [AW-1:0] la, logic [DW-1:0] ld,
                        logic re, logic rw, logic [AW-1:0] ra, logic [DW-1:0] rd);
    leftEn = le; leftWe = lw; leftAddr = la; leftWrData = ld;
    rightEn = re; rightWe = rw; rightAddr = ra; rightWrData = rd;
    @(negedge clk);
  endtask

  task automatic idle();
    access(0, 0, '0, '0, 0, 0, '0, '0);
  endtask

  task automatic tReset();
    check("R1 leftBusy", leftBusy, 0);
    check("R1 rightBusy", rightBusy, 0);
    check("R1 leftRdData", leftRdData, 0);
    check("R1 rightRdData", rightRdData, 0);
    check("R1 collKind", collKind, 0);
  endtask

  task automatic tBasic();
    access(1, 1, 4'd3, 16'h1111, 1, 1, 4'd5, 16'h2222);
    check("R3 busy after split writes", {leftBusy, rightBusy}, 0);
    check("R3 kind after split writes", collKind, 0);
    access(1, 0, 4'd5, '0, 1, 0, 4'd3, '0);
    check("R2 left reads word 5", leftRdData, 16'h2222);
    check("R2 right reads word 3", rightRdData, 16'h1111);
    check("R3 kind after split reads", collKind, 0);
  endtask

  task automatic tReadRead();
    access(1, 0, 4'd3, '0, 1, 0, 4'd3, '0);
    check("R4 left data", leftRdData, 16'h1111);
    check("R4 right data", rightRdData, 16'h1111);
    check("R4 busy", {leftBusy, rightBusy}, 0);
    check("R4 kind", collKind, 1);
  endtask

  task automatic tWriteWrite();
    access(1, 1, 4'd7, 16'hAAAA, 1, 1, 4'd7, 16'hBBBB);
    check("R5 rightBusy", rightBusy, 1);
    check("R5 leftBusy", leftBusy, 0);
    check("R5 kind", collKind, 2);
    access(1, 0, 4'd7, '0, 0, 0, '0, '0);
    check("R5 left data kept", leftRdData, 16'hAAAA);
    check("R7 busy cleared", {leftBusy, rightBusy}, 0);
    check("R7 kind cleared", collKind, 0);
  endtask

  task automatic tReadWrite();
    access(1, 0, 4'd3, '0, 1, 1, 4'd3, 16'h3333);
    check("R6 left reader old data", leftRdData, 16'h1111);
    check("R6 left reader busy", leftBusy, 1);
    check("R6 right writer not busy", rightBusy, 0);
    check("R6 kind", collKind, 3);
    access(1, 0, 4'd3, '0, 0, 0, '0, '0);
    check("R6 right write landed", leftRdData, 16'h3333);
    access(1, 1, 4'd5, 16'h5555, 1, 0, 4'd5, '0);
    check("R6 right reader old data", rightRdData, 16'h2222);
    check("R6 right reader busy", rightBusy, 1);
    check("R6 left writer not busy", leftBusy, 0);
    check("R6 kind mirrored", collKind, 3);
    access(0, 0, '0, '0, 1, 0, 4'd5, '0);
    check("R6 left write landed", rightRdData, 16'h5555);
    check("R7 busy cleared", {leftBusy, rightBusy}, 0);
  endtask

  task automatic tHold();
    access(1, 0, 4'd3, '0, 0, 0, '0, '0);
    check("R8 left read baseline", leftRdData, 16'h3333);
    access(1, 1, 4'd9, 16'h9999, 0, 0, '0, '0);
    check("R8 left holds during write", leftRdData, 16'h3333);
    idle();
    check("R8 left holds when idle", leftRdData, 16'h3333);
    check("R8 right holds when idle", rightRdData, 16'h5555);
  endtask

  task automatic tDisabled();
    access(1, 1, 4'd3, 16'h4444, 0, 0, 4'd3, '0);
    check("R3 disabled port no busy", {leftBusy, rightBusy}, 0);
    check("R3 disabled port no kind", collKind, 0);
    check("R3 disabled right no read", rightRdData, 16'h5555);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tBasic();
    tReadRead();
    tWriteWrite();
    tReadWrite();
    tHold();
    tDisabled();
    idle();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule